// File: doc/BRIEF.md
# Pace Scheduling Level with Overrun Detection

This block models a single priority level of a transmit pace scheduler. A circular table of time slots is filled by a real-time scheduling pointer, which writes one channel number per write strobe. A service pointer drains occupied slots, in the order they were written, into a bounded transmit queue. A downstream transmitter pops that queue. A reserved null channel code (zero) marks an empty pacing slot. The service pointer steps over such a slot without queueing anything.

When the transmit queue is full, the service pointer stalls. If the scheduler keeps writing, it laps the service pointer. The block does not block the writer in that case. It keeps writing, overwrites the oldest unserviced slot and drags the service pointer along. One scheduling pass is lost and the channel rates fall, but every entry already in the queue is kept. The collision raises an overrun pulse that carries this level's index. The pulse re-arms only after the service pointer makes real progress.

A bypass command puts a channel directly into the queue and takes the queue's write port for that cycle. When the queue is full, the bypass fails and raises a queue-full pulse that carries the requesting channel. A serviced channel with no complete cell ready causes an underrun: the idle code goes into the queue in place of the channel, and a pulse names the channel. The channel remains in the schedule, so every later service of it repeats the underrun until data is ready.

Top module: `pace_level`

States of the overrun tracker: ARMED (a collision is reported) and TRIPPED (a collision is suppressed). Transitions: ARMED to TRIPPED on a collision, which emits the pulse. TRIPPED to ARMED on any real service-pointer advance, whether a push or a null skip.

## Requirements
- R1: A channel written by the scheduler reaches the transmit queue in write order. It becomes the queue head (q_valid=1, q_chan) after the edge on which the service pointer serves its slot, one edge after the write.
- R2: A slot holding channel code 0 is consumed by the service pointer without any entry being added to the queue.
- R3: The queue holds QDEPTH entries. While it is full, q_full=1 and the service pointer does not advance over a non-null slot.
- R4: A scheduler write that finds DEPTH slots pending, with no service advance in that cycle, is a collision. The collision sets ovr_pulse for one cycle after the edge, with ovr_level equal to the LEVEL parameter.
- R5: On a collision, the write overwrites the oldest pending slot and the service pointer moves past it. The remaining DEPTH entries are then served in write order.
- R6: During one stall, only the first collision pulses. A later collision pulses again only after the service pointer has advanced.
- R7: A bypass with a non-full queue appends byp_chan to the queue. It has priority over the service pointer in that cycle.
- R8: A bypass with a full queue leaves the queue unchanged. It sets tqf_pulse for one cycle, with tqf_chan equal to the requested channel.
- R9: Serving channel c while chan_ready[c]=0 appends idle code 0 instead of c. It sets unr_pulse for one cycle, with unr_chan=c.
- R10: The underrun repeats each time the unready channel is served again. Nothing removes the channel from the schedule.
- R11: After reset the queue is empty, no slot is pending, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sch_we | input | 1 | Scheduler writes one slot this cycle |
| sch_chan | input | CHW | Channel written into the slot (0 = empty) |
| byp_valid | input | 1 | Bypass request |
| byp_chan | input | CHW | Channel to bypass into the queue |
| tx_pop | input | 1 | Transmitter removes the queue head |
| chan_ready | input | 2**CHW | Per-channel "complete cell available" |
| q_valid | output | 1 | Queue not empty |
| q_chan | output | CHW | Queue head (0 = idle cell) |
| q_full | output | 1 | Queue holds QDEPTH entries |
| ovr_pulse | output | 1 | Scheduling table overrun |
| ovr_level | output | LVLW | Level index reported with the overrun |
| tqf_pulse | output | 1 | Bypass failed on a full queue |
| tqf_chan | output | CHW | Channel of the failed bypass |
| unr_pulse | output | 1 | Transmit underrun |
| unr_chan | output | CHW | Channel that underran |

## Verification
The bench drives the scheduler with single ready channels, with null slots and with unready channels. Comparing the queue head with the written channel separates normal service from skip and from idle substitution. Bypasses against a queue with space and against a full queue separate the queued path from the failed path. A stalled queue under continued writing shows whether the writer blocks or overwrites: the drained sequence must begin with the third write and hold exactly DEPTH entries. Two stalls in succession, with service in between, show whether the overrun pulse re-arms.

// File: rtl/pace_pkg.sv
package pace_pkg;
    typedef enum logic [0:0] {
        OVR_ARMED   = 1'b0,
        OVR_TRIPPED = 1'b1
    } ovr_state_t;
endpackage

// File: rtl/pace_slot_ring.sv
module pace_slot_ring #(
    parameter int DEPTH = 16,
    parameter int CHW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CHW-1:0] wchan,
    input  logic           q_full,
    input  logic           port_busy,
    output logic           svc_push,
    output logic [CHW-1:0] svc_chan,
    output logic           svc_adv,
    output logic           collide
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CHW-1:0] slots [DEPTH];
    logic [PW-1:0]  wr_idx, svc_idx;
    logic [CW-1:0]  pend;
    logic           have, is_null, skip;

    assign have     = (pend != '0);
    assign svc_chan = slots[svc_idx];
    assign is_null  = (svc_chan == '0);
    assign skip     = have && is_null;
    assign svc_push = have && !is_null && !q_full && !port_busy;
    assign svc_adv  = skip || svc_push;
    assign collide  = we && (pend == CW'(DEPTH)) && !svc_adv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            wr_idx  <= '0;
            svc_idx <= '0;
            pend    <= '0;
        end else begin
            if (svc_adv) slots[svc_idx] <= '0;
            if (we)      slots[wr_idx]  <= wchan;
            if (we)      wr_idx  <= wr_idx + 1'b1;
            if (svc_adv || collide) svc_idx <= svc_idx + 1'b1;
            if (we && !(svc_adv || collide))      pend <= pend + 1'b1;
            else if (!we && svc_adv)              pend <= pend - 1'b1;
        end
    end

    // R4
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CW'(DEPTH));
    // R5
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> pend == CW'(DEPTH));
endmodule

// File: rtl/pace_txq.sv
module pace_txq #(
    parameter int QDEPTH = 4,
    parameter int CHW    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [CHW-1:0] din,
    input  logic           pop,
    output logic           valid,
    output logic [CHW-1:0] head,
    output logic           full
);
    localparam int QPW = $clog2(QDEPTH);
    localparam int QCW = $clog2(QDEPTH + 1);

    logic [CHW-1:0] mem [QDEPTH];
    logic [QPW-1:0] rd, wr;
    logic [QCW-1:0] cnt;
    logic           do_push, do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == QCW'(QDEPTH));
    assign head    = mem[rd];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) mem[i] <= '0;
            rd  <= '0;
            wr  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wr] <= din;
                wr      <= wr + 1'b1;
            end
            if (do_pop) rd <= rd + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= QCW'(QDEPTH));
    // R1
    drain_by_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(pop));
endmodule

// File: rtl/pace_ovr_fsm.sv
module pace_ovr_fsm
    import pace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic collide,
    input  logic svc_adv,
    output logic ovr_pulse
);
    ovr_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OVR_ARMED:   if (collide) state_nx = OVR_TRIPPED;
            OVR_TRIPPED: if (svc_adv) state_nx = OVR_ARMED;
            default:     state_nx = OVR_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OVR_ARMED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovr_pulse <= 1'b0;
        else        ovr_pulse <= (state == OVR_ARMED) && collide;
    end

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |=> !ovr_pulse);
endmodule

// File: rtl/pace_level.sv
module pace_level #(
    parameter int DEPTH  = 16,
    parameter int QDEPTH = 4,
    parameter int CHW    = 4,
    parameter int LVLW   = 3,
    parameter int LEVEL  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sch_we,
    input  logic [CHW-1:0]    sch_chan,
    input  logic              byp_valid,
    input  logic [CHW-1:0]    byp_chan,
    input  logic              tx_pop,
    input  logic [2**CHW-1:0] chan_ready,
    output logic              q_valid,
    output logic [CHW-1:0]    q_chan,
    output logic              q_full,
    output logic              ovr_pulse,
    output logic [LVLW-1:0]   ovr_level,
    output logic              tqf_pulse,
    output logic [CHW-1:0]    tqf_chan,
    output logic              unr_pulse,
    output logic [CHW-1:0]    unr_chan
);
    localparam logic [CHW-1:0] IDLE_CODE = '0;

    logic           ring_push, svc_adv, collide, byp_ok, push, unr_now;
    logic [CHW-1:0] svc_chan, din;

    pace_slot_ring #(.DEPTH(DEPTH), .CHW(CHW)) u_ring (
        .clk(clk), .rst_n(rst_n), .we(sch_we), .wchan(sch_chan),
        .q_full(q_full), .port_busy(byp_valid),
        .svc_push(ring_push), .svc_chan(svc_chan),
        .svc_adv(svc_adv), .collide(collide)
    );

    assign byp_ok  = byp_valid && !q_full;
    assign unr_now = ring_push && !chan_ready[svc_chan];
    assign push    = byp_ok || ring_push;
    assign din     = byp_ok ? byp_chan : (unr_now ? IDLE_CODE : svc_chan);

    pace_txq #(.QDEPTH(QDEPTH), .CHW(CHW)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(tx_pop),
        .valid(q_valid), .head(q_chan), .full(q_full)
    );

    pace_ovr_fsm u_ovr (
        .clk(clk), .rst_n(rst_n), .collide(collide),
        .svc_adv(svc_adv), .ovr_pulse(ovr_pulse)
    );

    assign ovr_level = LVLW'(LEVEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tqf_pulse <= 1'b0;
            tqf_chan  <= '0;
            unr_pulse <= 1'b0;
            unr_chan  <= '0;
        end else begin
            tqf_pulse <= byp_valid && q_full;
            if (byp_valid && q_full) tqf_chan <= byp_chan;
            unr_pulse <= unr_now;
            if (unr_now) unr_chan <= svc_chan;
        end
    end

    // R8
    bypass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && q_full) |=> (tqf_pulse && tqf_chan == $past(byp_chan)));
    // R9
    underrun_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unr_pulse |-> q_valid);
endmodule

// File: tb/sim_pace_level.sv
module sim_pace_level;
    localparam int DEPTH = 4, QDEPTH = 2, CHW = 4, LVLW = 3, LEVEL = 5;
    localparam int NCH = 2 ** CHW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sch_we = 1'b0, byp_valid = 1'b0, tx_pop = 1'b0;
    logic [CHW-1:0] sch_chan = '0, byp_chan = '0;
    logic [NCH-1:0] chan_ready = '1;
    logic q_valid, q_full, ovr_pulse, tqf_pulse, unr_pulse;
    logic [CHW-1:0] q_chan, tqf_chan, unr_chan;
    logic [LVLW-1:0] ovr_level;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pace_level #(.DEPTH(DEPTH), .QDEPTH(QDEPTH), .CHW(CHW), .LVLW(LVLW), .LEVEL(LEVEL)) u0 (
        .clk(clk), .rst_n(rst_n), .sch_we(sch_we), .sch_chan(sch_chan),
        .byp_valid(byp_valid), .byp_chan(byp_chan), .tx_pop(tx_pop),
        .chan_ready(chan_ready), .q_valid(q_valid), .q_chan(q_chan),
        .q_full(q_full), .ovr_pulse(ovr_pulse), .ovr_level(ovr_level),
        .tqf_pulse(tqf_pulse), .tqf_chan(tqf_chan),
        .unr_pulse(unr_pulse), .unr_chan(unr_chan)
    );

    typedef struct packed {
        logic we; logic [3:0] wch; logic bv; logic [3:0] bch; logic pop; logic rdy7;
        logic qv; logic [3:0] qch; logic full; logic ovr;
        logic tqf; logic [3:0] tch; logic unr; logic [3:0] uch;
    } vec_t;

    // we wch bv bch pop rdy7 | qv qch full ovr tqf tch unr uch
    localparam vec_t VECS [16] = '{
        '{1,3,0,0,0,1, 0,0,0,0, 0,0,0,0},  // R11 write ch3
        '{0,0,0,0,0,1, 1,3,0,0, 0,0,0,0},  // R1 ch3 served
        '{1,0,0,0,0,1, 1,3,0,0, 0,0,0,0},  // R2 null slot written
        '{0,0,0,0,0,1, 1,3,0,0, 0,0,0,0},  // R2 null skipped
        '{1,7,0,0,0,1, 1,3,0,0, 0,0,0,0},
        '{0,0,0,0,0,0, 1,3,1,0, 0,0,1,7},  // R9 idle pushed
        '{0,0,1,9,0,1, 1,3,1,0, 1,9,0,0},  // R8 bypass refused
        '{0,0,0,0,1,1, 1,0,0,0, 0,0,0,0},
        '{0,0,1,9,0,1, 1,0,1,0, 0,0,0,0},  // R7 bypass queued
        '{0,0,0,0,1,1, 1,9,0,0, 0,0,0,0},
        '{0,0,0,0,1,1, 0,0,0,0, 0,0,0,0},
        '{1,7,0,0,0,0, 0,0,0,0, 0,0,0,0},
        '{1,7,0,0,0,0, 1,0,0,0, 0,0,1,7},  // R10 first underrun
        '{0,0,0,0,0,0, 1,0,1,0, 0,0,1,7},  // R10 repeated underrun
        '{0,0,0,0,1,1, 1,0,0,0, 0,0,0,0},
        '{0,0,0,0,1,1, 0,0,0,0, 0,0,0,0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input int wch, input logic bv, input int bch,
                       input logic pop, input logic rdy7);
        sch_we = we; sch_chan = CHW'(wch);
        byp_valid = bv; byp_chan = CHW'(bch);
        tx_pop = pop; chan_ready = '1; chan_ready[7] = rdy7;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 q_valid", int'(q_valid), 0);
        chk("R11 q_full", int'(q_full), 0);
        chk("R11 pulses", int'({ovr_pulse, tqf_pulse, unr_pulse}), 0);

        foreach (VECS[i]) begin
            cyc(VECS[i].we, VECS[i].wch, VECS[i].bv, VECS[i].bch, VECS[i].pop, VECS[i].rdy7);
            chk("R1 q_valid", int'(q_valid), int'(VECS[i].qv));
            if (VECS[i].qv) chk("R1 q_chan", int'(q_chan), int'(VECS[i].qch));
            chk("R3 q_full", int'(q_full), int'(VECS[i].full));
            chk("R4 ovr_pulse", int'(ovr_pulse), int'(VECS[i].ovr));
            chk("R8 tqf_pulse", int'(tqf_pulse), int'(VECS[i].tqf));
            if (VECS[i].tqf) chk("R8 tqf_chan", int'(tqf_chan), int'(VECS[i].tch));
            chk("R9 unr_pulse", int'(unr_pulse), int'(VECS[i].unr));
            if (VECS[i].unr) chk("R9 unr_chan", int'(unr_chan), int'(VECS[i].uch));
        end

        // R3/R4: stall the queue, then lap the table
        cyc(0, 0, 1, 1, 0, 1);
        cyc(0, 0, 1, 2, 0, 1);
        chk("R3 full after bypasses", int'(q_full), 1);
        for (int k = 0; k < DEPTH; k++) cyc(1, 10 + k, 0, 0, 0, 1);
        chk("R4 no overrun at DEPTH pending", int'(ovr_pulse), 0);
        cyc(1, 14, 0, 0, 0, 1);
        chk("R4 overrun pulse", int'(ovr_pulse), 1);
        chk("R4 level index", int'(ovr_level), LEVEL);
        cyc(1, 15, 0, 0, 0, 1);
        chk("R6 second collision silent", int'(ovr_pulse), 0);
        // R5: drain; oldest two slots overwritten, order C D E F
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 head after first pop", int'(q_chan), 2);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 first surviving slot", int'(q_chan), 12);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R3 full again", int'(q_full), 1);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 second slot", int'(q_chan), 13);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 overwriting slot E", int'(q_chan), 14);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 overwriting slot F", int'(q_chan), 15);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R5 nothing more queued", int'(q_valid), 0);

        // R6: re-armed by service, new collision pulses again
        cyc(0, 0, 1, 1, 0, 1);
        cyc(0, 0, 1, 2, 0, 1);
        for (int k = 0; k < DEPTH; k++) cyc(1, 3, 0, 0, 0, 1);
        chk("R6 quiet before collision", int'(ovr_pulse), 0);
        cyc(1, 4, 0, 0, 0, 1);
        chk("R6 rearmed pulse", int'(ovr_pulse), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule